// File: doc/BRIEF.md
# Descriptor Cache Flush Engine

This block runs flush commands against a small direct-mapped descriptor cache. A command names a 40-bit descriptor address and a set of option bits. The engine writes the matching line back to memory if it is dirty, and then either drops the line or keeps it as a clean copy. Before the flush it can wait for the queue that the descriptor controls to drain. After the flush it can also flush a companion extended descriptor. It can sweep the entire cache instead of a single line.

A table of four address-blocking resources lets a command fence off its own address once the flush is done. The engine refuses a block on a resource that is already held and a release of a resource that is free, and it reports either refusal as an error. A whole-cache block covers every lookup until a separate unblock input clears it. A lookup port stands in for the cache's clients. It shows the effect of the flushes (hit or miss) and of the blocks (refused or served).

Write-back and queue drain are modelled as request/acknowledge handshakes. Only one command is in flight at a time. When the command asks for it, a status record with the command number and a result code is returned.

Top module: `dcache_flush_engine`

## Requirements
- R1: `cmd_ready` is high only while no command is in progress. It falls in the cycle after a command is accepted. It returns once the status record has been taken, or when the command finishes if no status was asked for.
- R2: A status record is presented if and only if bit 16 of `cmd_word0` is 1. It echoes bits 15:0 as the command number. Its code is 0 on success, 1 when a release targets a free resource, and 2 when a block targets a resource that is already held. It is held stable until `status_ready`.
- R3: The flush address is `{cmd_word2[7:0], cmd_addr_lo}`. A single-line flush of a valid dirty matching line issues exactly one write-back at that address, holding `wb_req` and `wb_addr` until `wb_ack`, and then invalidates the line, so the next lookup of the address misses.
- R4: With keep-valid (`cmd_word2` bit 12) the line is written back and left valid and clean. A repeat flush causes no write-back, and a lookup still hits.
- R5: With block-after-flush (bit 13), the resource picked by bits 11:10 is bound to the address after the flush. Lookups of that address are then refused, and other addresses are still served.
- R6: A block request on a held resource without release (bit 9 = 0) returns code 2. No write-back happens, the resource keeps its old address, and the line stays valid.
- R7: With release (bit 9), a held resource is freed before the rest of the command runs, so the same command can rebind it. Releasing a free resource returns code 1 and executes nothing.
- R8: With queue drain (bit 8), `drain_req` is raised with the flush address and completes on `drain_done` before any write-back starts.
- R9: With extended flush (bit 15), a second flush of address + 0x40 (parameter `EXT_OFF`) follows the primary flush.
- R10: With whole-cache flush (bit 14), every dirty line is written back in ascending line order and every line is invalidated. All other option bits are ignored and the resource table is unchanged. All lookups are then refused until a cache unblock.
- R11: A lookup is answered in the next cycle with `acc_done`. It is refused (`acc_blocked`=1, `acc_hit`=0) if the address matches an active resource, if the cache is blocked, or if a command is in progress. A served lookup reports a hit and installs the line as valid and dirty.
- R12: `unblk_res_valid` frees the resource named by `unblk_res_idx`, and `unblk_cache_valid` clears the whole-cache block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_word0 | input | 17 | [15:0] command number, [16] status wanted |
| cmd_addr_lo | input | 32 | Flush address bits 31:0 |
| cmd_word2 | input | 16 | [7:0] address bits 39:32, [15:8] option bits |
| status_valid | output | 1 | Status record valid |
| status_ready | input | 1 | Status record taken |
| status_num | output | 16 | Echoed command number |
| status_code | output | 2 | Result code |
| acc_valid | input | 1 | Lookup request |
| acc_addr | input | 40 | Lookup address |
| acc_done | output | 1 | Lookup answered |
| acc_hit | output | 1 | Lookup hit a valid line |
| acc_blocked | output | 1 | Lookup refused |
| unblk_res_valid | input | 1 | Free one blocking resource |
| unblk_res_idx | input | 2 | Resource to free |
| unblk_cache_valid | input | 1 | Clear the whole-cache block |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | 40 | Write-back line address |
| wb_ack | input | 1 | Write-back accepted |
| drain_req | output | 1 | Queue drain request |
| drain_addr | output | 40 | Descriptor whose queue drains |
| drain_done | input | 1 | Queue drain complete |

## Verification
Flushes are run against lines in known states: dirty, clean after a keep-valid flush, and free. The write-back count then separates the invalidating flush, the keep-valid flush and a refused command, and the next lookup's hit shows whether the line survived. Block, double-block, release-and-rebind and release-of-free commands are applied to the same resource. Lookups of the bound and unbound addresses afterwards show that the table changed only when the command succeeded. A drain-plus-extended command records the order of the drain and the two write-backs. Two whole-cache sweeps, the second with a known set of dirty lines and with all other option bits set, show the write-back count, the invalidation, the untouched resource and the block that lasts until unblock.

// File: rtl/flush_pkg.sv
package flush_pkg;
  localparam int FLUSH_AW = 40;
  localparam int RES_N    = 4;
  localparam int RES_IW   = $clog2(RES_N);

  typedef enum logic [3:0] {
    S_IDLE, S_DECODE, S_DRAIN, S_LOOK, S_WB, S_UPD, S_DONE, S_STAT
  } fsm_e;

  typedef enum logic [1:0] {
    CODE_OK       = 2'd0,
    CODE_WAS_FREE = 2'd1,
    CODE_WAS_HELD = 2'd2
  } code_e;

  // option byte, MSB first: decoded from command word bits 15:8
  typedef struct packed {
    logic              ext;
    logic              all;
    logic              blk;
    logic              keep;
    logic [RES_IW-1:0] idx;
    logic              rel;
    logic              fwd;
  } opt_t;
endpackage

// File: rtl/flush_blk_table.sv
module flush_blk_table
  import flush_pkg::*;
#(
  parameter int AW = FLUSH_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     look_addr,
  input  logic              set_en,
  input  logic [RES_IW-1:0] set_idx,
  input  logic [AW-1:0]     set_addr,
  input  logic              rel_en,
  input  logic [RES_IW-1:0] rel_idx,
  input  logic              unblk_en,
  input  logic [RES_IW-1:0] unblk_idx,
  input  logic              cache_set,
  input  logic              cache_clr,
  output logic [RES_N-1:0]  res_act,
  output logic              cache_blk,
  output logic              look_blocked
);
  logic [RES_N-1:0] hit_vec;

  for (genvar g = 0; g < RES_N; g++) begin : g_res
    logic [AW-1:0] addr_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        res_act[g] <= 1'b0;
        addr_q     <= '0;
      end else if (set_en && set_idx == RES_IW'(g)) begin
        res_act[g] <= 1'b1;
        addr_q     <= set_addr;
      end else if ((rel_en && rel_idx == RES_IW'(g)) ||
                   (unblk_en && unblk_idx == RES_IW'(g))) begin
        res_act[g] <= 1'b0;
      end
    end
    assign hit_vec[g] = res_act[g] && (addr_q == look_addr);
  end

  always_ff @(posedge clk) begin
    if (rst)            cache_blk <= 1'b0;
    else if (cache_set) cache_blk <= 1'b1;
    else if (cache_clr) cache_blk <= 1'b0;
  end

  assign look_blocked = cache_blk || (|hit_vec);
endmodule

// File: rtl/flush_line_store.sv
module flush_line_store
  import flush_pkg::*;
#(
  parameter int AW       = FLUSH_AW,
  parameter int LINES    = 8,
  parameter int LINE_LSB = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            probe_addr,
  input  logic                     fill_en,
  output logic                     probe_hit,
  input  logic [$clog2(LINES)-1:0] rd_idx,
  output logic                     rd_valid,
  output logic                     rd_dirty,
  output logic [AW-1:0]            rd_tag,
  input  logic                     upd_en,
  input  logic [$clog2(LINES)-1:0] upd_idx,
  input  logic                     upd_inval
);
  localparam int IDXW = $clog2(LINES);

  logic [LINES-1:0] valid_q, dirty_q;
  logic [AW-1:0]    tag_mem [LINES];
  logic [IDXW-1:0]  fill_idx;

  assign fill_idx = probe_addr[LINE_LSB +: IDXW];

  // tag storage: plain write port, no reset, suits distributed RAM
  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_idx] <= probe_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[fill_idx] <= 1'b1;
        dirty_q[fill_idx] <= 1'b1;
      end
      if (upd_en) begin
        dirty_q[upd_idx] <= 1'b0;
        if (upd_inval) valid_q[upd_idx] <= 1'b0;
      end
    end
  end

  assign probe_hit = valid_q[fill_idx] && (tag_mem[fill_idx] == probe_addr);
  assign rd_valid  = valid_q[rd_idx];
  assign rd_dirty  = dirty_q[rd_idx];
  assign rd_tag    = tag_mem[rd_idx];
endmodule

// File: rtl/flush_seq.sv
module flush_seq
  import flush_pkg::*;
#(
  parameter int             AW       = FLUSH_AW,
  parameter int             LINES    = 8,
  parameter int             LINE_LSB = 4,
  parameter logic [AW-1:0]  EXT_OFF  = 'h40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [15:0]              cmd_num,
  input  logic                     cmd_want,
  input  logic [AW-1:0]            cmd_addr,
  input  opt_t                     cmd_opt,
  output logic                     status_valid,
  input  logic                     status_ready,
  output logic [15:0]              status_num,
  output logic [1:0]               status_code,
  output logic                     wb_req,
  output logic [AW-1:0]            wb_addr,
  input  logic                     wb_ack,
  output logic                     drain_req,
  output logic [AW-1:0]            drain_addr,
  input  logic                     drain_done,
  output logic [$clog2(LINES)-1:0] rd_idx,
  input  logic                     rd_valid,
  input  logic                     rd_dirty,
  input  logic [AW-1:0]            rd_tag,
  output logic                     upd_en,
  output logic [$clog2(LINES)-1:0] upd_idx,
  output logic                     upd_inval,
  input  logic [RES_N-1:0]         res_act,
  output logic                     rel_en,
  output logic [RES_IW-1:0]        rel_idx,
  output logic                     set_en,
  output logic [RES_IW-1:0]        set_idx,
  output logic [AW-1:0]            set_addr,
  output logic                     cache_set
);
  localparam int IDXW = $clog2(LINES);

  fsm_e            st_q;
  code_e           code_q;
  opt_t            opt_q;
  logic [15:0]     num_q;
  logic            want_q, ext_q, hit_q;
  logic [AW-1:0]   base_q, cur_q, wba_q;
  logic [IDXW-1:0] ptr_q;

  logic look_hit, res_held, last_line, final_step;

  assign rd_idx     = opt_q.all ? ptr_q : cur_q[LINE_LSB +: IDXW];
  assign look_hit   = rd_valid && (opt_q.all || rd_tag == cur_q);
  assign res_held   = res_act[opt_q.idx];
  assign last_line  = (ptr_q == IDXW'(LINES - 1));
  assign final_step = !opt_q.all && !(opt_q.ext && !ext_q);

  assign cmd_ready    = (st_q == S_IDLE);
  assign status_valid = (st_q == S_STAT);
  assign status_num   = num_q;
  assign status_code  = code_q;
  assign wb_req       = (st_q == S_WB);
  assign wb_addr      = wba_q;
  assign drain_req    = (st_q == S_DRAIN);
  assign drain_addr   = base_q;
  assign upd_en       = (st_q == S_UPD) && hit_q;
  assign upd_idx      = rd_idx;
  assign upd_inval    = opt_q.all || !opt_q.keep;
  assign rel_en       = (st_q == S_DECODE) && !opt_q.all && opt_q.rel && res_held;
  assign rel_idx      = opt_q.idx;
  assign set_en       = (st_q == S_UPD) && final_step && opt_q.blk;
  assign set_idx      = opt_q.idx;
  assign set_addr     = base_q;
  assign cache_set    = (st_q == S_UPD) && opt_q.all && last_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      code_q <= CODE_OK;
      opt_q  <= '0;
      num_q  <= '0;
      want_q <= 1'b0;
      ext_q  <= 1'b0;
      hit_q  <= 1'b0;
      base_q <= '0;
      cur_q  <= '0;
      wba_q  <= '0;
      ptr_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (cmd_valid) begin
          num_q  <= cmd_num;
          want_q <= cmd_want;
          opt_q  <= cmd_opt;
          base_q <= cmd_addr;
          cur_q  <= cmd_addr;
          ext_q  <= 1'b0;
          ptr_q  <= '0;
          code_q <= CODE_OK;
          st_q   <= S_DECODE;
        end
        S_DECODE: begin
          if (opt_q.all)                              st_q <= S_LOOK;
          else if (opt_q.rel && !res_held) begin
            code_q <= CODE_WAS_FREE;
            st_q   <= S_DONE;
          end else if (opt_q.blk && res_held && !opt_q.rel) begin
            code_q <= CODE_WAS_HELD;
            st_q   <= S_DONE;
          end else                                    st_q <= opt_q.fwd ? S_DRAIN : S_LOOK;
        end
        S_DRAIN: if (drain_done) st_q <= S_LOOK;
        S_LOOK: begin
          hit_q <= look_hit;
          wba_q <= rd_tag;
          st_q  <= (look_hit && rd_dirty) ? S_WB : S_UPD;
        end
        S_WB: if (wb_ack) st_q <= S_UPD;
        S_UPD: begin
          if (opt_q.all) begin
            if (last_line) st_q <= S_DONE;
            else begin
              ptr_q <= ptr_q + 1'b1;
              st_q  <= S_LOOK;
            end
          end else if (opt_q.ext && !ext_q) begin
            ext_q <= 1'b1;
            cur_q <= base_q + EXT_OFF;
            st_q  <= S_LOOK;
          end else st_q <= S_DONE;
        end
        S_DONE: st_q <= want_q ? S_STAT : S_IDLE;
        S_STAT: if (status_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_flush_engine.sv
module dcache_flush_engine
  import flush_pkg::*;
#(
  parameter int                   LINES    = 8,
  parameter int                   LINE_LSB = 4,
  parameter logic [FLUSH_AW-1:0]  EXT_OFF  = 'h40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [16:0]         cmd_word0,
  input  logic [31:0]         cmd_addr_lo,
  input  logic [15:0]         cmd_word2,
  output logic                status_valid,
  input  logic                status_ready,
  output logic [15:0]         status_num,
  output logic [1:0]          status_code,
  input  logic                acc_valid,
  input  logic [FLUSH_AW-1:0] acc_addr,
  output logic                acc_done,
  output logic                acc_hit,
  output logic                acc_blocked,
  input  logic                unblk_res_valid,
  input  logic [RES_IW-1:0]   unblk_res_idx,
  input  logic                unblk_cache_valid,
  output logic                wb_req,
  output logic [FLUSH_AW-1:0] wb_addr,
  input  logic                wb_ack,
  output logic                drain_req,
  output logic [FLUSH_AW-1:0] drain_addr,
  input  logic                drain_done
);
  localparam int AW   = FLUSH_AW;
  localparam int IDXW = $clog2(LINES);

  logic [AW-1:0]     cmd_addr;
  opt_t              cmd_opt;
  logic [IDXW-1:0]   rd_idx, upd_idx;
  logic              rd_valid, rd_dirty, upd_en, upd_inval;
  logic [AW-1:0]     rd_tag, set_addr;
  logic [RES_N-1:0]  res_act;
  logic              rel_en, set_en, cache_set, cache_blk_w;
  logic [RES_IW-1:0] rel_idx, set_idx;
  logic              look_blocked, probe_hit, busy, refuse, fill_en;

  assign cmd_addr = {cmd_word2[7:0], cmd_addr_lo};
  assign cmd_opt  = opt_t'(cmd_word2[15:8]);
  assign busy     = !cmd_ready;
  assign refuse   = look_blocked || busy;
  assign fill_en  = acc_valid && !refuse;

  flush_seq #(.AW(AW), .LINES(LINES), .LINE_LSB(LINE_LSB), .EXT_OFF(EXT_OFF)) u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_num(cmd_word0[15:0]), .cmd_want(cmd_word0[16]),
    .cmd_addr(cmd_addr), .cmd_opt(cmd_opt),
    .status_valid(status_valid), .status_ready(status_ready),
    .status_num(status_num), .status_code(status_code),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
    .drain_req(drain_req), .drain_addr(drain_addr), .drain_done(drain_done),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_inval(upd_inval),
    .res_act(res_act), .rel_en(rel_en), .rel_idx(rel_idx),
    .set_en(set_en), .set_idx(set_idx), .set_addr(set_addr),
    .cache_set(cache_set)
  );

  flush_blk_table #(.AW(AW)) u_tbl (
    .clk(clk), .rst(rst),
    .look_addr(acc_addr),
    .set_en(set_en), .set_idx(set_idx), .set_addr(set_addr),
    .rel_en(rel_en), .rel_idx(rel_idx),
    .unblk_en(unblk_res_valid), .unblk_idx(unblk_res_idx),
    .cache_set(cache_set), .cache_clr(unblk_cache_valid),
    .res_act(res_act), .cache_blk(cache_blk_w), .look_blocked(look_blocked)
  );

  flush_line_store #(.AW(AW), .LINES(LINES), .LINE_LSB(LINE_LSB)) u_store (
    .clk(clk), .rst(rst),
    .probe_addr(acc_addr), .fill_en(fill_en), .probe_hit(probe_hit),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_inval(upd_inval)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_done    <= 1'b0;
      acc_hit     <= 1'b0;
      acc_blocked <= 1'b0;
    end else begin
      acc_done    <= acc_valid;
      acc_blocked <= acc_valid && refuse;
      acc_hit     <= acc_valid && !refuse && probe_hit;
    end
  end
endmodule

// File: rtl/flush_engine_chk.sv
module flush_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        status_valid,
  input logic        status_ready,
  input logic [15:0] status_num,
  input logic [1:0]  status_code,
  input logic        wb_req,
  input logic        wb_ack,
  input logic [39:0] wb_addr,
  input logic        drain_req,
  input logic        drain_done,
  input logic        acc_valid,
  input logic        acc_done,
  input logic        acc_hit,
  input logic        acc_blocked,
  input logic        cache_blk
);
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_ready); // R1
  AST_STATUS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    status_valid |-> !cmd_ready); // R2
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    status_valid && !status_ready |=> status_valid && $stable(status_num) && $stable(status_code)); // R2
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
    wb_req && !wb_ack |=> wb_req && $stable(wb_addr)); // R3
  AST_WB_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> !cmd_ready); // R3
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    drain_req && !drain_done |=> drain_req); // R8
  AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
    !(wb_req && drain_req)); // R8
  AST_ACC_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> acc_done); // R11
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !cmd_ready |=> acc_blocked && !acc_hit); // R11
  AST_CACHE_BLOCK_REFUSES: assert property (@(posedge clk) disable iff (rst)
    acc_valid && cache_blk |=> acc_blocked && !acc_hit); // R10
endmodule

bind dcache_flush_engine flush_engine_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .status_valid(status_valid), .status_ready(status_ready),
  .status_num(status_num), .status_code(status_code),
  .wb_req(wb_req), .wb_ack(wb_ack), .wb_addr(wb_addr),
  .drain_req(drain_req), .drain_done(drain_done),
  .acc_valid(acc_valid), .acc_done(acc_done), .acc_hit(acc_hit),
  .acc_blocked(acc_blocked), .cache_blk(cache_blk_w)
);

// File: tb/tb_dcache_flush_engine.sv
module tb_dcache_flush_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [16:0] cmd_word0 = '0;
  logic [31:0] cmd_addr_lo = '0;
  logic [15:0] cmd_word2 = '0;
  logic        status_valid, status_ready = 1'b1;
  logic [15:0] status_num;
  logic [1:0]  status_code;
  logic        acc_valid = 1'b0;
  logic [39:0] acc_addr = '0;
  logic        acc_done, acc_hit, acc_blocked;
  logic        unblk_res_valid = 1'b0;
  logic [1:0]  unblk_res_idx = '0;
  logic        unblk_cache_valid = 1'b0;
  logic        wb_req, wb_ack = 1'b0;
  logic [39:0] wb_addr, drain_addr;
  logic        drain_req, drain_done = 1'b0;

  always #2 clk = ~clk;

  dcache_flush_engine dut (.*);

  int n_chk = 0, n_fail = 0;
  int wb_cnt = 0, drain_cnt = 0, evt = 0, drain_seq = 0, dwait = 0;
  logic [39:0] wb_log [64];
  int          wb_seq [64];
  logic [39:0] drain_log = '0;
  int          st_seen;
  logic [15:0] st_num;
  logic [1:0]  st_code;

  localparam logic [39:0] A = 40'h12_0000_0010, B = 40'h12_0000_0020,
    C = 40'h12_0000_0030, D = 40'h12_0000_0050, E = 40'h34_0000_0060,
    F = 40'h34_0000_0070, G = 40'h56_0000_0000, H = 40'h56_0000_0010,
    EXT = 40'h40;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // write-back responder
  initial forever begin
    @(negedge clk);
    if (wb_req && !wb_ack) begin
      if (wb_cnt < 64) begin
        wb_log[wb_cnt] = wb_addr;
        wb_seq[wb_cnt] = evt;
      end
      wb_cnt++; evt++;
      wb_ack = 1'b1;
    end else wb_ack = 1'b0;
  end

  // drain responder, answers after a few cycles
  initial forever begin
    @(negedge clk);
    if (drain_req && !drain_done) begin
      if (dwait == 4) begin
        drain_done = 1'b1; drain_seq = evt; evt++; drain_cnt++;
        drain_log = drain_addr; dwait = 0;
      end else dwait++;
    end else drain_done = 1'b0;
  end

  function automatic logic [15:0] opts(bit fwd, bit rel, logic [1:0] idx, bit keep,
                                       bit blk, bit all, bit ext, logic [7:0] hi);
    return {ext, all, blk, keep, idx, rel, fwd, hi};
  endfunction

  task automatic issue(logic [15:0] num, bit want, logic [39:0] addr, logic [15:0] o);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word0 = {want, num};
    cmd_addr_lo = addr[31:0];
    cmd_word2 = {o[15:8], addr[39:32]};
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_cmd();
    st_seen = 0;
    for (int i = 0; i < 1000; i++) begin
      if (status_valid) begin
        st_seen++; st_num = status_num; st_code = status_code;
      end
      if (cmd_ready) break;
      @(negedge clk);
    end
    chk("R1", "ready after command", cmd_ready, 1);
  endtask

  task automatic run(logic [15:0] num, bit want, logic [39:0] addr, logic [15:0] o);
    issue(num, want, addr, o);
    finish_cmd();
  endtask

  task automatic access(logic [39:0] addr);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = addr;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "ready at reset", cmd_ready, 1);
    chk("R2", "no status at reset", status_valid, 0);
    chk("R3", "no wb at reset", wb_req, 0);
    chk("R8", "no drain at reset", drain_req, 0);
    chk("R11", "no acc_done at reset", acc_done, 0);
  endtask

  task automatic t_fill_hit();
    access(A);
    chk("R11", "first lookup done", acc_done, 1);
    chk("R11", "first lookup misses", acc_hit, 0);
    chk("R11", "first lookup served", acc_blocked, 0);
    access(A);
    chk("R11", "second lookup hits", acc_hit, 1);
  endtask

  task automatic t_single_flush();
    int w0 = wb_cnt;
    run(16'h0101, 1, A, 16'h0);
    chk("R2", "status seen once", st_seen, 1);
    chk("R2", "status number", st_num, 16'h0101);
    chk("R2", "status ok", st_code, 0);
    chk("R3", "one write-back", wb_cnt - w0, 1);
    chk("R3", "write-back address", wb_log[w0], A);
    access(A);
    chk("R3", "line invalidated", acc_hit, 0);
  endtask

  task automatic t_no_inval();
    int w0;
    access(B);
    w0 = wb_cnt;
    run(16'h0202, 1, B, opts(0, 0, 0, 1, 0, 0, 0, 0));
    chk("R4", "keep-valid writes back", wb_cnt - w0, 1);
    w0 = wb_cnt;
    run(16'h0203, 1, B, opts(0, 0, 0, 1, 0, 0, 0, 0));
    chk("R4", "clean line no write-back", wb_cnt - w0, 0);
    access(B);
    chk("R4", "line still valid", acc_hit, 1);
  endtask

  task automatic t_no_status();
    int w0 = wb_cnt;
    run(16'h0303, 0, A, 16'h0);
    chk("R2", "no status when not asked", st_seen, 0);
    chk("R3", "flush without status runs", wb_cnt - w0, 1);
  endtask

  task automatic t_block();
    int w0;
    access(C);
    w0 = wb_cnt;
    run(16'h0404, 1, C, opts(0, 0, 1, 0, 1, 0, 0, 0));
    chk("R5", "block status ok", st_code, 0);
    chk("R5", "block flushes", wb_cnt - w0, 1);
    access(C);
    chk("R5", "bound address refused", acc_blocked, 1);
    chk("R5", "refused lookup no hit", acc_hit, 0);
    access(D);
    chk("R5", "other address served", acc_blocked, 0);
  endtask

  task automatic t_double_block();
    int w0;
    access(E);
    w0 = wb_cnt;
    run(16'h0505, 1, E, opts(0, 0, 1, 0, 1, 0, 0, 0));
    chk("R6", "double block code", st_code, 2);
    chk("R6", "no write-back on error", wb_cnt - w0, 0);
    access(C);
    chk("R6", "old binding kept", acc_blocked, 1);
    access(E);
    chk("R6", "new address not bound", acc_blocked, 0);
    chk("R6", "line not flushed", acc_hit, 1);
  endtask

  task automatic t_release_reuse();
    int w0 = wb_cnt;
    run(16'h0606, 1, E, opts(0, 1, 1, 0, 1, 0, 0, 0));
    chk("R7", "release and rebind ok", st_code, 0);
    chk("R7", "rebind flushes", wb_cnt - w0, 1);
    access(C);
    chk("R7", "old address freed", acc_blocked, 0);
    access(E);
    chk("R7", "new address bound", acc_blocked, 1);
  endtask

  task automatic t_release_free();
    int w0;
    access(F);
    w0 = wb_cnt;
    run(16'h0707, 1, F, opts(0, 1, 2, 0, 0, 0, 0, 0));
    chk("R7", "release free code", st_code, 1);
    chk("R7", "nothing executed", wb_cnt - w0, 0);
    access(F);
    chk("R7", "line untouched", acc_hit, 1);
  endtask

  task automatic t_unblock_res();
    @(negedge clk);
    unblk_res_valid = 1'b1; unblk_res_idx = 2'd1;
    @(negedge clk);
    unblk_res_valid = 1'b0;
    access(E);
    chk("R12", "resource unblocked", acc_blocked, 0);
  endtask

  task automatic t_drain_ext();
    int w0, d0;
    access(G);
    access(G + EXT);
    w0 = wb_cnt; d0 = drain_cnt;
    issue(16'h0808, 1, G, opts(1, 0, 0, 0, 0, 0, 1, 0));
    for (int i = 0; i < 50 && !drain_req; i++) @(negedge clk);
    access(D);
    chk("R11", "lookup refused while busy", acc_blocked, 1);
    finish_cmd();
    chk("R8", "drain ok status", st_code, 0);
    chk("R8", "one drain", drain_cnt - d0, 1);
    chk("R8", "drain address", drain_log, G);
    chk("R9", "two write-backs", wb_cnt - w0, 2);
    chk("R9", "primary first", wb_log[w0], G);
    chk("R9", "extended second", wb_log[w0 + 1], G + EXT);
    chk("R8", "drain before write-back", drain_seq < wb_seq[w0], 1);
    chk("R9", "primary before extended", wb_seq[w0] < wb_seq[w0 + 1], 1);
  endtask

  task automatic t_entire();
    int w0;
    logic [15:0] all_opts = opts(1, 1, 0, 1, 1, 1, 1, 0);
    access(H);
    run(16'h0909, 1, H, opts(0, 0, 0, 0, 1, 0, 0, 0));
    chk("R5", "bind resource 0", st_code, 0);
    run(16'h0A0A, 1, B, all_opts);
    chk("R10", "sweep status ok", st_code, 0);
    access(D);
    chk("R10", "cache blocked after sweep", acc_blocked, 1);
    @(negedge clk); unblk_cache_valid = 1'b1;
    @(negedge clk); unblk_cache_valid = 1'b0;
    access(H);
    chk("R10", "resource 0 unchanged", acc_blocked, 1);
    access(D);
    chk("R12", "cache unblocked", acc_blocked, 0);
    access(A);
    access(F);
    w0 = wb_cnt;
    run(16'h0B0B, 1, B, all_opts);
    chk("R10", "sweep writes dirty lines", wb_cnt - w0, 3);
    chk("R10", "sweep order 1", wb_log[w0], A);
    chk("R10", "sweep order 2", wb_log[w0 + 1], D);
    chk("R10", "sweep order 3", wb_log[w0 + 2], F);
    @(negedge clk); unblk_cache_valid = 1'b1;
    @(negedge clk); unblk_cache_valid = 1'b0;
    access(A);
    chk("R10", "keep ignored, line invalid", acc_hit, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill_hit();
    t_single_flush();
    t_no_inval();
    t_no_status();
    t_block();
    t_double_block();
    t_release_reuse();
    t_release_free();
    t_unblock_res();
    t_drain_ext();
    t_entire();
    repeat (4) @(negedge clk);
    report();
  end
endmodule